// File: doc/BRIEF.md
# Host Register Port with Event Status and Interrupt

This block is the host-facing register front end of a network controller. The host reaches every register through a small bus with three ports. One port loads an 8-bit index pointer. The other two ports are data ports. Each data port opens its own register space, either status/control or configuration, at whatever index the pointer currently holds. Because the two spaces share one pointer, software loads the index once and can then touch either space.

The main status/control register collects event flags from the MAC side: a missed receive frame, a memory error, a receive-done event, and a collision error. Software clears each flag by writing a one to its bit, so it can clear a set of flags by writing back the value it just read. A read-only summary error bit reports whether any error flag is set. A registered, active-low interrupt output combines the flags that may interrupt, under a global enable and per-flag masks. The collision-error flag comes from a window test. After each transmission in half-duplex operation, the collision input must assert within a fixed number of bit times, or the flag is set. A missed-frame counter keeps a running total of lost frames.

Top module: `hostRegPort`

## Requirements
- R1: The pointer port (busAddr = 0) holds an 8-bit index. A write loads busWData[7:0], and busWData[15:8] is ignored. A read returns the index in bits 7:0 and zero in bits 15:8.
- R2: The same index selects the register for both data ports. Status port busAddr = 1. Configuration port busAddr = 2, where indices 0 to CFG_COUNT-1 are 16-bit read/write registers. Configuration register 0 bit 0 selects full duplex (1) or half duplex (0).
- R3: The pointer is cleared by hardware reset (rstN low) and by software reset (softRst high at a clock edge). Writes to the status register, including the stop bit, leave it unchanged.
- R4: Main status register (status index 0) layout: bit 13 collision error, bit 12 missed frame, bit 11 memory error, bit 10 receive done, bit 6 interrupt enable (read/write), bit 2 stop (read/write). Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R5: Bit 15 of the main status register reads as the OR of the collision-error, missed-frame and memory-error flags. Writes to bit 15 have no effect.
- R6: In half-duplex mode, a txEnd pulse opens a window of SQE_BITS (default 20) bitTick pulses. If the 20th tick arrives with no colIn seen since txEnd, the collision-error flag is set. A colIn high during the window cancels the test. A new txEnd restarts the test. In full-duplex mode, no test runs.
- R7: The collision-error flag never affects intN. It is cleared by a 1 written to its bit, by either reset, or by any main-status write that has bit 2 (stop) set.
- R8: A missEvt pulse sets the missed-frame flag. The flag drives intN low only when interrupt enable is 1 and its mask bit (mask register at status index 3, bit 12) is 0. Mask bits 11 and 10 mask memory error and receive done.
- R9: Status index 48 returns a 16-bit missed-frame counter. It increments on every missEvt, wraps at 16 bits, and ignores writes.
- R10: When a flag's set event and a write-1 clear of that flag arrive in the same cycle, the flag ends up set.
- R11: intN is registered and active low. One cycle after the flags change, it goes low if interrupt enable is set and any of missed frame, memory error or receive done is set with its mask bit clear.
- R12: Reads of unmapped indices, or of busAddr = 3, return zero. Writes to them change no register.
- R13: After reset, all registers read zero and intN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| softRst | input | 1 | Synchronous software reset |
| busAddr | input | 2 | Port select: 0 pointer, 1 status data, 2 configuration data |
| busWr | input | 1 | Write strobe for the selected port |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data of the selected port (combinational) |
| missEvt | input | 1 | Receive frame lost for lack of a descriptor |
| memErrEvt | input | 1 | Memory error event |
| rxDoneEvt | input | 1 | Receive completed event |
| txEnd | input | 1 | Pulse at the end of a transmission |
| colIn | input | 1 | Collision indication from the line side |
| bitTick | input | 1 | One pulse per network bit time |
| intN | output | 1 | Interrupt request, active low |

## Verification
The bench drives the collision window right up to its edge. It checks that nothing is set after 19 ticks and that the flag is set on the 20th. An off-by-one counter would flag one tick early or late. A test that ignored cancellation or duplex would flag transmissions that saw a collision, or that ran in full duplex. It also fires a set event in the same cycle as its write-1 clear, where a clear-wins design would lose the event. It checks that a collision error never pulls the interrupt low, that writes to the summary bit and the counter change nothing, and that the pointer survives a stop write but not a software reset. A long random phase mixes writes to mapped and unmapped indices with events, and compares every cycle against a behavioural model.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int PTR_W  = 8;
  localparam int DATA_W = 16;

  localparam logic [1:0] PORT_PTR = 2'd0;
  localparam logic [1:0] PORT_STS = 2'd1;
  localparam logic [1:0] PORT_CFG = 2'd2;

  localparam int B_ERR  = 15;
  localparam int B_COLL = 13;
  localparam int B_MISS = 12;
  localparam int B_MEM  = 11;
  localparam int B_RX   = 10;
  localparam int B_IE   = 6;
  localparam int B_STOP = 2;

  typedef struct packed {
    logic             ptrWr;
    logic             stsWr;
    logic             mskWr;
    logic             cfgWr;
    logic [PTR_W-1:0] idx;
    logic             collSet;
    logic             missSet;
    logic             memSet;
    logic             rxSet;
  } strobe_t;
endpackage

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
  import hrp_pkg::*;
#(
  parameter int CFG_COUNT = 4,
  parameter int SQE_BITS  = 20,
  parameter int MASK_IDX  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic [PTR_W-1:0] ptr,
  input  logic             fullDuplex,
  input  logic             missEvt,
  input  logic             memErrEvt,
  input  logic             rxDoneEvt,
  input  logic             txEnd,
  input  logic             colIn,
  input  logic             bitTick,
  output strobe_t          stb
);
  localparam int WIN_W = $clog2(SQE_BITS + 1);
  localparam logic [WIN_W-1:0] LAST_TICK = WIN_W'(SQE_BITS - 1);

  logic             armed;
  logic [WIN_W-1:0] winCnt;
  logic             startTest;
  logic             lastTick;

  assign startTest = txEnd && !fullDuplex;
  assign lastTick  = armed && !fullDuplex && !colIn && bitTick && (winCnt == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      winCnt <= '0;
    end else if (softRst) begin
      armed  <= 1'b0;
      winCnt <= '0;
    end else if (startTest) begin
      armed  <= 1'b1;
      winCnt <= '0;
    end else if (armed) begin
      if (fullDuplex || colIn) begin
        armed <= 1'b0;
      end else if (bitTick) begin
        if (winCnt == LAST_TICK) armed <= 1'b0;
        else                     winCnt <= winCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb     = '0;
    stb.idx = ptr;
    if (busWr) begin
      unique case (busAddr)
        PORT_PTR: stb.ptrWr = 1'b1;
        PORT_STS: begin
          if (ptr == '0)                  stb.stsWr = 1'b1;
          else if (ptr == PTR_W'(MASK_IDX)) stb.mskWr = 1'b1;
        end
        PORT_CFG: stb.cfgWr = (32'(ptr) < CFG_COUNT);
        default: ;
      endcase
    end
    stb.collSet = lastTick && !startTest;
    stb.missSet = missEvt;
    stb.memSet  = memErrEvt;
    stb.rxSet   = rxDoneEvt;
  end

  // R6: the window counter never runs past the last tick
  p_win_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (winCnt <= LAST_TICK));

  // R6: no collision error can be raised while in full duplex
  p_no_fd_coll_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.collSet |-> !fullDuplex);

  // R6: a collision during the window disarms the test
  p_col_cancel_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && colIn && !txEnd && !softRst) |=> !armed);
endmodule

// File: rtl/hrp_dp.sv
module hrp_dp
  import hrp_pkg::*;
#(
  parameter int CFG_COUNT    = 4,
  parameter int MASK_IDX     = 3,
  parameter int MISS_CNT_IDX = 48,
  parameter int CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  strobe_t           stb,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic [PTR_W-1:0]  ptr,
  output logic              fullDuplex,
  output logic              intN
);
  logic collErr, missFrm, memErr, rxDone;
  logic intEn, stopBit;
  logic missMsk, memMsk, rxMsk;
  logic [CNT_W-1:0] missCnt;
  logic [DATA_W-1:0] cfgReg [CFG_COUNT];
  logic errSum, intReq;

  function automatic logic flagNext(logic cur, logic setEv, logic clrEv);
    return setEv | (cur & ~clrEv);
  endfunction

  logic clrColl;
  assign clrColl = stb.stsWr && (busWData[B_COLL] || busWData[B_STOP]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (softRst) begin
      ptr <= '0;
    end else if (stb.ptrWr) begin
      ptr <= busWData[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      collErr <= 1'b0; missFrm <= 1'b0; memErr <= 1'b0; rxDone <= 1'b0;
      intEn   <= 1'b0; stopBit <= 1'b0;
      missMsk <= 1'b0; memMsk  <= 1'b0; rxMsk  <= 1'b0;
      missCnt <= '0;
      intN    <= 1'b1;
    end else if (softRst) begin
      collErr <= 1'b0; missFrm <= 1'b0; memErr <= 1'b0; rxDone <= 1'b0;
      intEn   <= 1'b0; stopBit <= 1'b0;
      missMsk <= 1'b0; memMsk  <= 1'b0; rxMsk  <= 1'b0;
      missCnt <= '0;
      intN    <= 1'b1;
    end else begin
      collErr <= flagNext(collErr, stb.collSet, clrColl);
      missFrm <= flagNext(missFrm, stb.missSet, stb.stsWr && busWData[B_MISS]);
      memErr  <= flagNext(memErr,  stb.memSet,  stb.stsWr && busWData[B_MEM]);
      rxDone  <= flagNext(rxDone,  stb.rxSet,   stb.stsWr && busWData[B_RX]);
      if (stb.stsWr) begin
        intEn   <= busWData[B_IE];
        stopBit <= busWData[B_STOP];
      end
      if (stb.mskWr) begin
        missMsk <= busWData[B_MISS];
        memMsk  <= busWData[B_MEM];
        rxMsk   <= busWData[B_RX];
      end
      if (stb.missSet) missCnt <= missCnt + 1'b1;
      intN <= ~intReq;
    end
  end

  for (genvar g = 0; g < CFG_COUNT; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 cfgReg[g] <= '0;
      else if (softRst)                          cfgReg[g] <= '0;
      else if (stb.cfgWr && stb.idx == PTR_W'(g)) cfgReg[g] <= busWData;
    end
  end

  assign fullDuplex = cfgReg[0][0];
  assign errSum     = collErr | missFrm | memErr;
  assign intReq     = intEn & ((missFrm & ~missMsk) | (memErr & ~memMsk) | (rxDone & ~rxMsk));

  always_comb begin
    busRData = '0;
    unique case (busAddr)
      PORT_PTR: busRData[PTR_W-1:0] = ptr;
      PORT_STS: begin
        if (ptr == '0) begin
          busRData[B_ERR]  = errSum;
          busRData[B_COLL] = collErr;
          busRData[B_MISS] = missFrm;
          busRData[B_MEM]  = memErr;
          busRData[B_RX]   = rxDone;
          busRData[B_IE]   = intEn;
          busRData[B_STOP] = stopBit;
        end else if (ptr == PTR_W'(MASK_IDX)) begin
          busRData[B_MISS] = missMsk;
          busRData[B_MEM]  = memMsk;
          busRData[B_RX]   = rxMsk;
        end else if (ptr == PTR_W'(MISS_CNT_IDX)) begin
          busRData[CNT_W-1:0] = missCnt;
        end
      end
      PORT_CFG: begin
        for (int i = 0; i < CFG_COUNT; i++)
          if (ptr == PTR_W'(i)) busRData = cfgReg[i];
      end
      default: ;
    endcase
  end

  // R10: a set event always leaves its flag set on the next cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.missSet && !softRst) |=> missFrm);

  // R4: a write-1 clear with no competing event empties the flag
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stsWr && busWData[B_MEM] && !stb.memSet && !softRst) |=> !memErr);

  // R7: collision error alone can never pull the interrupt low
  p_coll_noint_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!missFrm && !memErr && !rxDone) |=> intN);

  // R3: the pointer only moves on a pointer write or a reset
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.ptrWr && !softRst) |=> $stable(ptr));

  // R9: each missed frame advances the counter by one
  p_miss_cnt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.missSet && !softRst) |=> missCnt == $past(missCnt) + 1'b1);
endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hrp_pkg::*;
#(
  parameter int CFG_COUNT    = 4,
  parameter int SQE_BITS     = 20,
  parameter int MASK_IDX     = 3,
  parameter int MISS_CNT_IDX = 48,
  parameter int CNT_W        = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic [1:0]  busAddr,
  input  logic        busWr,
  input  logic [15:0] busWData,
  output logic [15:0] busRData,
  input  logic        missEvt,
  input  logic        memErrEvt,
  input  logic        rxDoneEvt,
  input  logic        txEnd,
  input  logic        colIn,
  input  logic        bitTick,
  output logic        intN
);
  strobe_t          stb;
  logic [PTR_W-1:0] ptr;
  logic             fullDuplex;

  hrp_ctrl #(.CFG_COUNT(CFG_COUNT), .SQE_BITS(SQE_BITS), .MASK_IDX(MASK_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .busAddr(busAddr), .busWr(busWr),
    .ptr(ptr), .fullDuplex(fullDuplex), .missEvt(missEvt), .memErrEvt(memErrEvt),
    .rxDoneEvt(rxDoneEvt), .txEnd(txEnd), .colIn(colIn), .bitTick(bitTick), .stb(stb)
  );

  hrp_dp #(.CFG_COUNT(CFG_COUNT), .MASK_IDX(MASK_IDX), .MISS_CNT_IDX(MISS_CNT_IDX),
           .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .softRst(softRst), .stb(stb), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .ptr(ptr), .fullDuplex(fullDuplex),
    .intN(intN)
  );
endmodule

// File: tb/hostRegPort_bench.sv
`timescale 1ns/1ps
module hostRegPort_bench;
  localparam int SQE = 20;

  logic clk = 0, rstN = 0, softRst = 0, busWr = 0;
  logic [1:0] busAddr = 0;
  logic [15:0] busWData = 0;
  logic [15:0] busRData;
  logic missEvt = 0, memErrEvt = 0, rxDoneEvt = 0, txEnd = 0, colIn = 0, bitTick = 0;
  logic intN;

  int nChecks = 0, nFails = 0;
  bit running = 0, done = 0;

  hostRegPort u_hostRegPort (.*);

  always #10 clk = ~clk;

  // behavioural reference model
  int mPtr, mCnt, mWin;
  bit mColl, mMiss, mMem, mRx, mIe, mStop, mMm, mMe, mMr, mIntN;
  int mCfg [4];

  task automatic mReset();
    mPtr = 0; mCnt = 0; mWin = 0;
    {mColl, mMiss, mMem, mRx, mIe, mStop, mMm, mMe, mMr} = '0;
    mIntN = 1;
    foreach (mCfg[i]) mCfg[i] = 0;
  endtask

  initial mReset();

  always @(posedge clk) begin
    if (!rstN || softRst) mReset();
    else begin
      bit fd, cs, stsW, nI;
      int p;
      fd = mCfg[0][0];
      p  = mPtr;
      nI = !(mIe && ((mMiss && !mMm) || (mMem && !mMe) || (mRx && !mMr)));
      cs = 0;
      if (txEnd && !fd) mWin = SQE;
      else if (mWin > 0) begin
        if (fd || colIn) mWin = 0;
        else if (bitTick) begin
          mWin--;
          if (mWin == 0) cs = 1;
        end
      end
      stsW = busWr && busAddr == 1 && p == 0;
      mColl = cs      || (mColl && !(stsW && (busWData[13] || busWData[2])));
      mMiss = missEvt || (mMiss && !(stsW && busWData[12]));
      mMem  = memErrEvt || (mMem && !(stsW && busWData[11]));
      mRx   = rxDoneEvt || (mRx && !(stsW && busWData[10]));
      if (stsW) begin mIe = busWData[6]; mStop = busWData[2]; end
      if (busWr && busAddr == 1 && p == 3) begin
        mMm = busWData[12]; mMe = busWData[11]; mMr = busWData[10];
      end
      if (missEvt) mCnt = (mCnt + 1) % 65536;
      if (busWr && busAddr == 2 && p < 4) mCfg[p] = busWData;
      if (busWr && busAddr == 0) mPtr = busWData[7:0];
      mIntN = nI;
    end
  end

  function automatic logic [15:0] mRead(logic [1:0] a);
    logic [15:0] v = 0;
    if (a == 0) v = 16'(mPtr);
    else if (a == 1) begin
      if (mPtr == 0) begin
        v[15] = mColl | mMiss | mMem; v[13] = mColl; v[12] = mMiss;
        v[11] = mMem; v[10] = mRx; v[6] = mIe; v[2] = mStop;
      end else if (mPtr == 3) begin
        v[12] = mMm; v[11] = mMe; v[10] = mMr;
      end else if (mPtr == 48) v = 16'(mCnt);
    end else if (a == 2) begin
      if (mPtr < 4) v = 16'(mCfg[mPtr]);
    end
    return v;
  endfunction

  function automatic string tagFor(logic [1:0] a);
    if (a == 0) return "R1";
    if (a == 2) return "R2";
    if (a == 1 && mPtr == 0) return "R4";
    if (a == 1 && mPtr == 3) return "R8";
    if (a == 1 && mPtr == 48) return "R9";
    return "R12";
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (running && !done) begin
      logic [15:0] exp;
      exp = mRead(busAddr);
      nChecks++;
      if (busRData !== exp) begin
        nFails++;
        $display("FAIL %s model read port %0d ptr %0d: actual %h expected %h",
                 tagFor(busAddr), busAddr, mPtr, busRData, exp);
      end
      nChecks++;
      if (intN !== mIntN) begin
        nFails++;
        $display("FAIL R11 model intN: actual %b expected %b", intN, mIntN);
      end
    end
  end

  task automatic step(); @(posedge clk); #5; endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask
  task automatic wr(logic [1:0] a, logic [15:0] d);
    busAddr = a; busWData = d; busWr = 1; step(); busWr = 0;
  endtask
  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask
  task automatic rdChk(string tag, logic [1:0] a, logic [15:0] exp);
    busAddr = a; #1; chk(tag, busRData, exp);
  endtask
  task automatic tick(); bitTick = 1; step(); bitTick = 0; step(); endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1; step();
    running = 1;
    // R13 reset state
    rdChk("R13 status", 1, 16'h0000);
    rdChk("R13 ptr", 0, 16'h0000);
    chk("R13 intN", 16'(intN), 16'h0001);
    // R1 pointer width
    wr(0, 16'hAB30); rdChk("R1 ptr upper ignored", 0, 16'h0030);
    // R2 config via shared pointer, R12 unmapped
    wr(0, 2); wr(2, 16'h1234); rdChk("R2 cfg2", 2, 16'h1234);
    rdChk("R12 status idx2", 1, 16'h0000);
    wr(1, 16'hFFFF); rdChk("R12 unmapped write", 1, 16'h0000);
    rdChk("R12 port3", 3, 16'h0000);
    wr(0, 0); rdChk("R2 cfg0", 2, 16'h0000);
    // R8 missed frame interrupt
    wr(1, 16'h0040);
    missEvt = 1; step(); missEvt = 0;
    rdChk("R8 R5 miss+err", 1, 16'h9040);
    step(); chk("R11 intN low", 16'(intN), 16'h0000);
    wr(0, 3); wr(1, 16'h1000); step();
    chk("R8 masked intN", 16'(intN), 16'h0001);
    // R9 counter
    wr(0, 48); rdChk("R9 count1", 1, 16'h0001);
    wr(1, 16'hFFFF); rdChk("R9 write ignored", 1, 16'h0001);
    for (int i = 0; i < 3; i++) begin missEvt = 1; step(); missEvt = 0; step(); end
    rdChk("R9 count4", 1, 16'h0004);
    // R4 / R5 write-one-to-clear
    wr(0, 0); wr(1, 16'h0040); rdChk("R4 zero keeps", 1, 16'h9040);
    wr(1, 16'h1040); rdChk("R4 cleared", 1, 16'h0040);
    wr(1, 16'h8040); rdChk("R5 err write ignored", 1, 16'h0040);
    // R10 set beats clear
    missEvt = 1; wr(1, 16'h1040); missEvt = 0;
    rdChk("R10 set wins", 1, 16'h9040);
    wr(1, 16'h1040);
    // R6 collision window boundary
    txEnd = 1; step(); txEnd = 0;
    for (int i = 0; i < SQE - 1; i++) tick();
    rdChk("R6 19 ticks clear", 1, 16'h0040);
    tick(); rdChk("R6 20th tick sets", 1, 16'hA040);
    idle(2); chk("R7 no interrupt", 16'(intN), 16'h0001);
    wr(1, 16'h0044); rdChk("R7 stop clears", 1, 16'h0044);
    rdChk("R3 ptr after stop", 0, 16'h0000);
    // R6 cancel by collision
    txEnd = 1; step(); txEnd = 0;
    for (int i = 0; i < 5; i++) tick();
    colIn = 1; step(); colIn = 0;
    for (int i = 0; i < SQE + 2; i++) tick();
    rdChk("R6 cancelled", 1, 16'h0044);
    // R6 full duplex
    wr(2, 16'h0001);
    txEnd = 1; step(); txEnd = 0;
    for (int i = 0; i < SQE + 3; i++) tick();
    rdChk("R6 full duplex", 1, 16'h0044);
    wr(2, 16'h0000);
    // R11 memory error and receive done
    wr(1, 16'h0040);
    memErrEvt = 1; step(); memErrEvt = 0; step();
    chk("R11 mem intN", 16'(intN), 16'h0000);
    wr(1, 16'h0840); step(); chk("R11 release", 16'(intN), 16'h0001);
    rxDoneEvt = 1; step(); rxDoneEvt = 0; step();
    chk("R11 rx intN", 16'(intN), 16'h0000);
    wr(1, 16'h0400); step(); chk("R11 released", 16'(intN), 16'h0001);
    // R3 soft reset
    wr(0, 5); softRst = 1; step(); softRst = 0;
    rdChk("R3 soft reset ptr", 0, 16'h0000);
    rdChk("R13 soft reset status", 1, 16'h0000);
    // random phase checked against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      busWr = (r < 30);
      busAddr = 2'($urandom_range(0, 3));
      busWData = 16'($urandom);
      if (busAddr == 0) begin
        case ($urandom_range(0, 4))
          0: busWData[7:0] = 0;
          1: busWData[7:0] = 3;
          2: busWData[7:0] = 48;
          3: busWData[7:0] = 8'($urandom_range(0, 5));
          default: ;
        endcase
      end
      missEvt   = ($urandom_range(0, 9) == 0);
      memErrEvt = ($urandom_range(0, 19) == 0);
      rxDoneEvt = ($urandom_range(0, 9) == 0);
      txEnd     = ($urandom_range(0, 59) == 0);
      colIn     = ($urandom_range(0, 39) == 0);
      bitTick   = ($urandom_range(0, 1) == 0);
      softRst   = ($urandom_range(0, 499) == 0);
      step();
    end
    {busWr, missEvt, memErrEvt, rxDoneEvt, txEnd, colIn, bitTick, softRst} = '0;
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule